// File: doc/BRIEF.md
# Shift and Rotate Unit

This block is the shifting part of a 32-bit integer execute stage. It is purely combinational. It receives the six-bit function code, the full instruction word and the two source operand values, called `rs` and `rt`. From these it returns the shifted or rotated copy of `rt` and a flag that marks the function code as one of its own. The register file, writeback and every other ALU operation sit outside the block.

Four operations are supported: logical left, logical right, arithmetic right and rotate right. Each operation has two forms. In the fixed form the amount comes from the five-bit amount field of the instruction, bits [10:6]. In the variable form the amount comes from the low five bits of `rs`.

Rotate right has no function code of its own. It shares a code with logical right shift, and one spare instruction bit picks between the two. That bit is bit 21 for the fixed form and bit 6 for the variable form.

Top module: `shift_rotate_unit`

## Requirements
- R1: With `valid_i` high and function code 0x00, the result is `rt` shifted left by `insn_i[10:6]` with zero fill, and `rs` has no effect.
- R2: Function code 0x02 gives a logical right shift of `rt` by `insn_i[10:6]` when `insn_i[21]` is 0. It gives a rotate right by the same amount, `(rt << (32-n)) | (rt >> n)`, when `insn_i[21]` is 1.
- R3: Function code 0x03 gives a right shift of `rt` by `insn_i[10:6]` in which every vacated bit is a copy of `rt[31]`.
- R4: Function code 0x04 gives `rt` shifted left by `rs[4:0]` with zero fill.
- R5: Function code 0x06 gives a logical right shift of `rt` by `rs[4:0]` when `insn_i[6]` is 0, and a rotate right by `rs[4:0]` when `insn_i[6]` is 1.
- R6: Function code 0x07 gives an arithmetic right shift of `rt` by `rs[4:0]`.
- R7: A rotate by an amount of zero, in either form, returns `rt` unchanged.
- R8: Bits [31:5] of `rs` never change the result of the variable forms.
- R9: The all-zero no-operation word (function 0x00, amount 0, `rt` value 0) gives a result of 0 with `known_o` high.
- R10: `known_o` is high exactly when `valid_i` is high and the function code is one of 0x00, 0x02, 0x03, 0x04, 0x06 or 0x07. When `known_o` is low, `res_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| valid_i | input | 1 | Instruction in the stage is real |
| func_i | input | 6 | Function code of the instruction |
| insn_i | input | 32 | Full instruction word: amount field and rotate-select bits |
| rs_i | input | 32 | First source operand; bits [4:0] give the variable amount |
| rt_i | input | 32 | Value to be shifted or rotated |
| res_o | output | 32 | Shift or rotate result, 0 when not recognised |
| known_o | output | 1 | Function code recognised and valid |

## Verification
The hardest case to reach from the ports is a rotate whose select bit is set and whose amount is exactly zero. Random words hit that pairing only about once in sixty-four tries per form, so the bench forces it directly in both forms.

Changes to `rs[31:5]` have no visible effect. To show this, the bench applies the same variable instruction twice, changing only the upper bits of `rs` between the two, and compares the two results. All six function codes, a mix of unlisted codes and dropped valid strobes are also drawn from a seeded random source.

// File: rtl/shifter_pkg.sv
package shifter_pkg;

  typedef enum logic [2:0] {
    SK_NONE = 3'd0,
    SK_LL   = 3'd1,
    SK_RL   = 3'd2,
    SK_RA   = 3'd3,
    SK_RR   = 3'd4
  } shift_kind_e;

  localparam logic [5:0] FN_LL_IMM = 6'h00;
  localparam logic [5:0] FN_RL_IMM = 6'h02;
  localparam logic [5:0] FN_RA_IMM = 6'h03;
  localparam logic [5:0] FN_LL_VAR = 6'h04;
  localparam logic [5:0] FN_RL_VAR = 6'h06;
  localparam logic [5:0] FN_RA_VAR = 6'h07;

  // true for the three function codes whose amount comes from a register
  function automatic logic is_var_form(input logic [5:0] fn);
    return (fn == FN_LL_VAR) || (fn == FN_RL_VAR) || (fn == FN_RA_VAR);
  endfunction

  // maps a code and its rotate-select bit to the operation kind
  function automatic shift_kind_e kind_of(input logic [5:0] fn, input logic rot_sel);
    case (fn)
      FN_LL_IMM, FN_LL_VAR: return SK_LL;
      FN_RL_IMM, FN_RL_VAR: return rot_sel ? SK_RR : SK_RL;
      FN_RA_IMM, FN_RA_VAR: return SK_RA;
      default:              return SK_NONE;
    endcase
  endfunction

endpackage

// File: rtl/shift_decode.sv
module shift_decode
  import shifter_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SA_LSB      = 6,
  parameter int ROT_IMM_BIT = 21,
  parameter int ROT_VAR_BIT = 6,
  localparam int AMT_W      = $clog2(DATA_W)
) (
  input  logic              valid_i,
  input  logic [5:0]        func_i,
  input  logic [DATA_W-1:0] insn_i,
  input  logic [DATA_W-1:0] rs_i,
  output shift_kind_e       kind_o,
  output logic [AMT_W-1:0]  amt_o,
  output logic              known_o
);

  logic        var_form;
  logic        rot_sel;
  shift_kind_e kind_raw;

  always_comb begin
    var_form = is_var_form(func_i);
    rot_sel  = var_form ? insn_i[ROT_VAR_BIT] : insn_i[ROT_IMM_BIT];
    kind_raw = kind_of(func_i, rot_sel);
    amt_o    = var_form ? rs_i[AMT_W-1:0] : insn_i[SA_LSB +: AMT_W];
    known_o  = valid_i && (kind_raw != SK_NONE);
    kind_o   = known_o ? kind_raw : SK_NONE;
  end

endmodule

// File: rtl/shift_core.sv
module shift_core
  import shifter_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  shift_kind_e       kind_i,
  output logic [DATA_W-1:0] dout_o
);

  logic go_left;
  logic go_rot;
  logic fill_bit;

  assign go_left  = (kind_i == SK_LL);
  assign go_rot   = (kind_i == SK_RR);
  assign fill_bit = (kind_i == SK_RA) && din_i[DATA_W-1];

  logic [DATA_W-1:0] stg [0:AMT_W];

  // left shifts run through the right-shifting ladder on a mirrored word
  for (genvar i = 0; i < DATA_W; i++) begin : g_mirror_in
    assign stg[0][i] = go_left ? din_i[DATA_W-1-i] : din_i[i];
  end

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [S-1:0] top_bits;
    assign top_bits   = go_rot ? stg[k][S-1:0] : {S{fill_bit}};
    assign stg[k+1]   = amt_i[k] ? {top_bits, stg[k][DATA_W-1:S]} : stg[k];
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_mirror_out
    assign dout_o[i] = go_left ? stg[AMT_W][DATA_W-1-i] : stg[AMT_W][i];
  end

endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import shifter_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SA_LSB      = 6,
  parameter int ROT_IMM_BIT = 21,
  parameter int ROT_VAR_BIT = 6
) (
  input  logic              valid_i,
  input  logic [5:0]        func_i,
  input  logic [DATA_W-1:0] insn_i,
  input  logic [DATA_W-1:0] rs_i,
  input  logic [DATA_W-1:0] rt_i,
  output logic [DATA_W-1:0] res_o,
  output logic              known_o
);

  localparam int AMT_W = $clog2(DATA_W);

  shift_kind_e       kind_w;
  logic [AMT_W-1:0]  amt_w;
  logic              known_w;
  logic [DATA_W-1:0] core_w;

  shift_decode #(
    .DATA_W(DATA_W), .SA_LSB(SA_LSB),
    .ROT_IMM_BIT(ROT_IMM_BIT), .ROT_VAR_BIT(ROT_VAR_BIT)
  ) u_dec (
    .valid_i(valid_i), .func_i(func_i), .insn_i(insn_i), .rs_i(rs_i),
    .kind_o(kind_w), .amt_o(amt_w), .known_o(known_w)
  );

  shift_core #(.DATA_W(DATA_W)) u_core (
    .din_i(rt_i), .amt_i(amt_w), .kind_i(kind_w), .dout_o(core_w)
  );

  assign known_o = known_w;
  assign res_o   = known_w ? core_w : '0;

endmodule

// File: rtl/shift_rotate_unit_chk.sv
module shift_rotate_unit_chk
  import shifter_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SA_LSB      = 6,
  parameter int ROT_IMM_BIT = 21,
  parameter int ROT_VAR_BIT = 6,
  localparam int AMT_W      = $clog2(DATA_W)
) (
  input logic              valid_i,
  input logic [5:0]        func_i,
  input logic [DATA_W-1:0] insn_i,
  input logic [DATA_W-1:0] rs_i,
  input logic [DATA_W-1:0] rt_i,
  input logic [DATA_W-1:0] res_o,
  input logic              known_o,
  input shift_kind_e       kind_w,
  input logic [AMT_W-1:0]  amt_w
);

  always_comb begin
    // R10: an unrecognised or invalid slot leaves a zero result
    a_r10_idle_zero: assert (known_o || res_o == '0);
    a_r10_needs_valid: assert (!known_o || valid_i);
    // R4: variable amount comes only from rs[4:0] (R8: upper bits unused)
    a_r4_var_amount: assert (!(known_o && is_var_form(func_i)) || amt_w == rs_i[AMT_W-1:0]);
    // R1: fixed amount comes from the instruction amount field
    a_r1_imm_amount: assert (!(known_o && !is_var_form(func_i)) || amt_w == insn_i[SA_LSB +: AMT_W]);
    // R7: zero-length rotate returns rt
    a_r7_rot_zero: assert (!(kind_w == SK_RR && amt_w == '0) || res_o == rt_i);
    // R3: arithmetic shift keeps the sign bit
    a_r3_sign_kept: assert (!(kind_w == SK_RA) || res_o[DATA_W-1] == rt_i[DATA_W-1]);
    // R2: rotate preserves the population of rt
    a_r2_rot_popcount: assert (!(kind_w == SK_RR) || $countones(res_o) == $countones(rt_i));
  end

endmodule

bind shift_rotate_unit shift_rotate_unit_chk #(
  .DATA_W(DATA_W), .SA_LSB(SA_LSB),
  .ROT_IMM_BIT(ROT_IMM_BIT), .ROT_VAR_BIT(ROT_VAR_BIT)
) u_chk (
  .valid_i(valid_i), .func_i(func_i), .insn_i(insn_i), .rs_i(rs_i),
  .rt_i(rt_i), .res_o(res_o), .known_o(known_o),
  .kind_w(kind_w), .amt_w(amt_w)
);

// File: tb/test_shift_rotate_unit.sv
module test_shift_rotate_unit;

  logic        clk = 1'b0;
  logic        valid_i;
  logic [5:0]  func_i;
  logic [31:0] insn_i, rs_i, rt_i, res_o;
  logic        known_o;
  int          n_checks = 0;
  int          n_errors = 0;

  always #10 clk = ~clk;

  shift_rotate_unit i_shift_rotate_unit (
    .valid_i(valid_i), .func_i(func_i), .insn_i(insn_i),
    .rs_i(rs_i), .rt_i(rt_i), .res_o(res_o), .known_o(known_o)
  );

  function automatic logic [32:0] model(input logic v, input logic [5:0] f,
                                        input logic [31:0] w, input logic [31:0] s,
                                        input logic [31:0] t);
    int n;
    logic [63:0] dbl;
    n = (f[2]) ? int'(s[4:0]) : int'(w[10:6]);
    dbl = {t, t} >> n;
    if (!v) return 33'd0;
    case (f)
      6'h00, 6'h04: return {1'b1, t << n};
      6'h02:        return {1'b1, w[21] ? dbl[31:0] : t >> n};
      6'h06:        return {1'b1, w[6]  ? dbl[31:0] : t >> n};
      6'h03, 6'h07: return {1'b1, 32'($signed(t) >>> n)};
      default:      return 33'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [5:0] f);
    case (f)
      6'h00: return "R1";
      6'h02: return "R2";
      6'h03: return "R3";
      6'h04: return "R4";
      6'h06: return "R5";
      6'h07: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic apply(input logic v, input logic [5:0] f, input logic [31:0] w,
                       input logic [31:0] s, input logic [31:0] t);
    @(negedge clk);
    valid_i = v; func_i = f; insn_i = w; rs_i = s; rt_i = t;
    #2;
  endtask

  task automatic check(input string tag, input logic [32:0] exp);
    n_checks++;
    if ({known_o, res_o} !== exp) begin
      n_errors++;
      $display("FAIL %s: got known=%0b res=%h, expected known=%0b res=%h",
               tag, known_o, res_o, exp[32], exp[31:0]);
    end
  endtask

  task automatic run_one(input string tag, input logic v, input logic [5:0] f,
                         input logic [31:0] w, input logic [31:0] s, input logic [31:0] t);
    apply(v, f, w, s, t);
    check(tag, model(v, f, w, s, t));
  endtask

  initial begin
    #3000000;
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [32:0] first;
    logic [5:0] picks [6] = '{6'h00, 6'h02, 6'h03, 6'h04, 6'h06, 6'h07};
    void'($urandom(32'd1234));

    // R10: idle state with no valid
    run_one("R10", 1'b0, 6'h00, 32'h0, 32'h0, 32'hFFFF_FFFF);
    // R9: all-zero no-operation
    run_one("R9", 1'b1, 6'h00, 32'h0, 32'h0, 32'h0);
    check("R9", 33'h1_0000_0000);
    // R1 / R3 boundaries
    run_one("R1", 1'b1, 6'h00, 32'd31 << 6, 32'hFFFF_FFFF, 32'h0000_0003);
    run_one("R3", 1'b1, 6'h03, 32'd31 << 6, 32'h0, 32'h8000_0000);
    run_one("R3", 1'b1, 6'h03, 32'd4 << 6, 32'h0, 32'h7000_0000);
    // R2 shift versus rotate on same amount
    run_one("R2", 1'b1, 6'h02, 32'd4 << 6, 32'h0, 32'h1234_5678);
    run_one("R2", 1'b1, 6'h02, (32'd4 << 6) | (32'd1 << 21), 32'h0, 32'h1234_5678);
    check("R2", {1'b1, 32'h8123_4567});
    // R5 variable rotate and shift
    run_one("R5", 1'b1, 6'h06, 32'h40, 32'd8, 32'hAABB_CCDD);
    check("R5", {1'b1, 32'hDDAA_BBCC});
    run_one("R5", 1'b1, 6'h06, 32'h0, 32'd8, 32'hAABB_CCDD);
    // R7 zero rotate in both forms
    run_one("R7", 1'b1, 6'h02, 32'd1 << 21, 32'h0, 32'hDEAD_BEEF);
    check("R7", {1'b1, 32'hDEAD_BEEF});
    run_one("R7", 1'b1, 6'h06, 32'h40, 32'hFFFF_FFE0, 32'hCAFE_F00D);
    check("R7", {1'b1, 32'hCAFE_F00D});
    // R8 upper rs bits ignored
    for (int k = 0; k < 3; k++) begin
      logic [5:0] f;
      f = (k == 0) ? 6'h04 : (k == 1) ? 6'h06 : 6'h07;
      apply(1'b1, f, 32'h40, 32'h0000_0005, 32'h9876_5432);
      first = {known_o, res_o};
      apply(1'b1, f, 32'h40, 32'hABCD_E125, 32'h9876_5432);
      check("R8", first);
    end
    // R4 / R6 directed
    run_one("R4", 1'b1, 6'h04, 32'h0, 32'd16, 32'h0000_FFFF);
    run_one("R6", 1'b1, 6'h07, 32'h0, 32'd1, 32'hF000_0000);
    // R10 unlisted codes
    run_one("R10", 1'b1, 6'h01, 32'hFFFF_FFFF, 32'h3, 32'hFFFF_FFFF);
    run_one("R10", 1'b1, 6'h05, 32'hFFFF_FFFF, 32'h3, 32'hFFFF_FFFF);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] f;
      logic v;
      f = ($urandom % 8 == 0) ? 6'($urandom) : picks[$urandom % 6];
      v = ($urandom % 16) != 0;
      run_one(v ? tag_of(f) : "R10", v, f, $urandom, $urandom, $urandom);
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule